// File: doc/BRIEF.md
# Carry-Chained Add and Masking Logic Execution Slice

This block is one integer execution slice of a processor pipeline. In one issue cycle it does one of six operations. Two are adds that use the incoming carry flag as an operand: one adds an all-ones constant and one adds zero. Both return a fresh carry flag. The other four are masking operations: a plain AND, an AND with an inverted second operand, and two forms that AND with a 16-bit immediate. One immediate form places the immediate in the low half and the other in the high half.

The result is captured in one output register stage. Along with it the slice can produce a 4-bit condition nibble with a write strobe. The nibble compares the result, as a signed number, against zero and also carries the incoming summary-overflow flag. The immediate masking forms always write the nibble. Every other form writes it only when the issuing instruction asks for a record. Decode from raw instruction words and the register file stay outside this block.

Top module: `exu_slice`

## Requirements
- R1: With op code 0, the result is A + carry_in + all-ones, taken modulo 2^32. carry_out is the unsigned carry out of bit 31 of that sum.
- R2: With op code 1, the result is A + carry_in. carry_out is the unsigned carry out of bit 31.
- R3: With op code 2 the result is A AND B. With op code 3 the result is A AND (NOT B).
- R4: With op code 4, the 16-bit immediate gets zeros above it (bits 31:16 are zero) and the result is A AND that value.
- R5: With op code 5, the immediate sits in bits 31:16 with zeros in bits 15:0, and the result is A AND that value.
- R6: For op codes 2 to 5, carry_out equals the carry_in that was presented with the operation.
- R7: The condition nibble is laid out as bit 3 = negative, bit 2 = positive, bit 1 = zero, bit 0 = the so_in value. The first three come from a signed comparison of the result with zero, and exactly one of them is set.
- R8: cond_we is 1 for every valid op code 4 or 5. For op codes 0 to 3, cond_we follows the record input. Otherwise cond_we is 0.
- R9: An operation issued at one rising clock edge appears at the outputs after that edge, with res_vld high. During a cycle with no issue, res_vld and cond_we are 0 and result and carry_out keep their values.
- R10: Op codes 6 and 7 are treated as no-ops. They give a result of 0, pass carry_in through to carry_out, and leave cond_we at 0.
- R11: While reset is asserted, result, carry_out, cond, cond_we and res_vld are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_vld | input | 1 | Operation present this cycle (clock enable) |
| op_sel | input | 3 | Operation code, 0 to 5 |
| record | input | 1 | Request a condition write for op codes 0 to 3 |
| opnd_a | input | 32 | Add source, or first masking source |
| opnd_b | input | 32 | Second masking source |
| imm | input | 16 | Immediate for op codes 4 and 5 |
| carry_in | input | 1 | Current carry flag |
| so_in | input | 1 | Current summary-overflow flag |
| result | output | 32 | Registered result |
| carry_out | output | 1 | Updated carry flag |
| cond | output | 4 | Condition nibble {neg, pos, zero, so} |
| cond_we | output | 1 | Condition nibble write strobe |
| res_vld | output | 1 | Result valid |

## Verification
Several checks run on every cycle. They cover the one-hot sign/zero bits, the zero bit against the result, the pass-through of the carry on masking ops, and the mandatory condition write for immediate ops. They also check two consequences of the carry adds: after an add-zero that produces a carry the result is zero, and after an add-all-ones with no carry the result is all ones. Exact results, operand layouts of the immediate, the handling of record on the register forms, no-op codes and idle hold behaviour can only be shown by the bench. It sweeps every op code, both carry values and both record values across a grid of corner operands and compares each against arithmetic computed in the bench.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XLEN = 32;
  localparam int IMMW = 16;

  typedef enum logic [2:0] {
    OP_ADDM1 = 3'd0,
    OP_ADDZ  = 3'd1,
    OP_AND   = 3'd2,
    OP_ANDC  = 3'd3,
    OP_ANDI  = 3'd4,
    OP_ANDIS = 3'd5
  } exu_op_e;

  typedef enum logic [1:0] {
    MSK_AND   = 2'd0,
    MSK_ANDC  = 2'd1,
    MSK_IMMLO = 2'd2,
    MSK_IMMHI = 2'd3
  } msk_sel_e;

  function automatic logic op_is_known(input logic [2:0] op);
    return (op <= 3'd5);
  endfunction

  function automatic logic op_is_imm(input logic [2:0] op);
    return (op == OP_ANDI) || (op == OP_ANDIS);
  endfunction

  function automatic logic op_is_add(input logic [2:0] op);
    return (op == OP_ADDM1) || (op == OP_ADDZ);
  endfunction
endpackage

// File: rtl/exu_carry_add.sv
module exu_carry_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  input  logic         cin,
  input  logic         add_ones,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int SW = W + 1;

  logic [SW-1:0] ext_src;
  logic [SW-1:0] ext_cin;
  logic [SW-1:0] ext_k;
  logic [SW-1:0] total;

  always_comb begin
    ext_src = {1'b0, src};
    ext_cin = {{W{1'b0}}, cin};
    ext_k   = add_ones ? {1'b0, {W{1'b1}}} : '0;
    total   = ext_src + ext_cin + ext_k;
    sum     = total[W-1:0];
    cout    = total[SW-1];
  end
endmodule

// File: rtl/exu_mask_logic.sv
module exu_mask_logic #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic [1:0]    sel,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [IW-1:0] imm,
  output logic [W-1:0]  y
);
  import exu_pkg::*;
  localparam int PAD = W - IW;

  logic [W-1:0] imm_lo;
  logic [W-1:0] imm_hi;

  generate
    if (PAD > 0) begin : g_pad
      assign imm_lo = {{PAD{1'b0}}, imm};
      assign imm_hi = {imm, {PAD{1'b0}}};
    end else begin : g_nopad
      assign imm_lo = imm[W-1:0];
      assign imm_hi = imm[W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (msk_sel_e'(sel))
      MSK_AND:   y = a & b;
      MSK_ANDC:  y = a & ~b;
      MSK_IMMLO: y = a & imm_lo;
      default:   y = a & imm_hi;
    endcase
  end
endmodule

// File: rtl/exu_cond_gen.sv
module exu_cond_gen #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic         so,
  output logic [3:0]   cond
);
  logic is_zero;
  logic is_neg;

  always_comb begin
    is_zero = (res == '0);
    is_neg  = res[W-1];
    cond[3] = is_neg;
    cond[2] = !is_neg && !is_zero;
    cond[1] = is_zero;
    cond[0] = so;
  end
endmodule

// File: rtl/exu_slice.sv
module exu_slice
  import exu_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IMMW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_vld,
  input  logic [2:0]    op_sel,
  input  logic          record,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [IW-1:0] imm,
  input  logic          carry_in,
  input  logic          so_in,
  output logic [W-1:0]  result,
  output logic          carry_out,
  output logic [3:0]    cond,
  output logic          cond_we,
  output logic          res_vld
);
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic [W-1:0] msk_y;
  logic [1:0]   msk_sel;
  logic [3:0]   cond_nx;

  logic [W-1:0] res_d,  res_q;
  logic         ca_d,   ca_q;
  logic [3:0]   cnd_d,  cnd_q;
  logic         we_d,   we_q;
  logic         vld_q;

  exu_carry_add #(.W(W)) u_add (
    .src(opnd_a), .cin(carry_in), .add_ones(op_sel == OP_ADDM1),
    .sum(add_sum), .cout(add_cout)
  );

  assign msk_sel = (op_sel == OP_ANDC)  ? 2'd1 :
                   (op_sel == OP_ANDI)  ? 2'd2 :
                   (op_sel == OP_ANDIS) ? 2'd3 : 2'd0;

  exu_mask_logic #(.W(W), .IW(IW)) u_msk (
    .sel(msk_sel), .a(opnd_a), .b(opnd_b), .imm(imm), .y(msk_y)
  );

  exu_cond_gen #(.W(W)) u_cnd (
    .res(res_d), .so(so_in), .cond(cond_nx)
  );

  // next-state
  always_comb begin
    res_d = '0;
    ca_d  = carry_in;
    we_d  = 1'b0;
    if (op_is_add(op_sel)) begin
      res_d = add_sum;
      ca_d  = add_cout;
    end else if (op_is_known(op_sel)) begin
      res_d = msk_y;
    end
    if (op_is_imm(op_sel))        we_d = 1'b1;
    else if (op_is_known(op_sel)) we_d = record;
    cnd_d = we_d ? cond_nx : 4'b0000;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ca_q  <= 1'b0;
      cnd_q <= 4'b0000;
      we_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= issue_vld;
      we_q  <= issue_vld & we_d;
      if (issue_vld) begin
        res_q <= res_d;
        ca_q  <= ca_d;
        cnd_q <= cnd_d;
      end
    end
  end

  assign result    = res_q;
  assign carry_out = ca_q;
  assign cond      = cnd_q;
  assign cond_we   = we_q;
  assign res_vld   = vld_q;

  // R7
  cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_we |-> ($countones(cond[3:1]) == 1));
  // R7
  cond_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_we |-> (cond[1] == (result == '0)));
  // R6
  logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && op_sel >= 3'd2 && op_sel <= 3'd5) |=> (carry_out == $past(carry_in)));
  // R8
  imm_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && (op_sel == 3'd4 || op_sel == 3'd5)) |=> cond_we);
  // R9
  we_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_we |-> res_vld);
  // R2
  addz_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && op_sel == 3'd1) |=> (!carry_out || result == '0));
  // R1
  addm1_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && op_sel == 3'd0) |=> (carry_out || result == '1));
endmodule

// File: tb/sim_exu_slice.sv
`timescale 1ns/1ps
module sim_exu_slice;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_vld;
  logic [2:0]  op_sel;
  logic        record;
  logic [31:0] opnd_a, opnd_b;
  logic [15:0] imm;
  logic        carry_in, so_in;
  logic [31:0] result;
  logic        carry_out;
  logic [3:0]  cond;
  logic        cond_we, res_vld;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  exu_slice u0 (
    .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .op_sel(op_sel),
    .record(record), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
    .carry_in(carry_in), .so_in(so_in), .result(result),
    .carry_out(carry_out), .cond(cond), .cond_we(cond_we), .res_vld(res_vld)
  );

  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h0000_FFFF;
      6: return 32'hFFFF_0000;
      default: return 32'hA5C3_5A3C;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic ci, input logic rc, input logic so);
    logic [32:0] s;
    logic [31:0] er;
    logic        ec, ew;
    logic [3:0]  ecnd;
    string       rq;
    @(negedge clk);
    issue_vld = 1'b1; op_sel = op[2:0]; record = rc;
    opnd_a = a; opnd_b = b; imm = b[15:0] ^ a[31:16]; carry_in = ci; so_in = so;
    ec = ci; er = 32'h0; ew = 1'b0;
    case (op)
      0: begin s = {1'b0, a} + {32'h0, ci} + 33'h0_FFFF_FFFF; er = s[31:0]; ec = s[32]; rq = "R1"; end
      1: begin s = {1'b0, a} + {32'h0, ci}; er = s[31:0]; ec = s[32]; rq = "R2"; end
      2: begin er = a & b; rq = "R3"; end
      3: begin er = a & ~b; rq = "R3"; end
      4: begin er = a & {16'h0, imm}; rq = "R4"; end
      5: begin er = a & {imm, 16'h0}; rq = "R5"; end
      default: rq = "R10";
    endcase
    if (op <= 3) ew = rc;
    else if (op <= 5) ew = 1'b1;
    ecnd = {$signed(er) < 0, $signed(er) > 0, er == 0, so};
    @(negedge clk);
    chk(rq, result, er);
    chk((op >= 2 && op <= 5) ? "R6" : rq, {31'h0, carry_out}, {31'h0, ec});
    chk("R8", {31'h0, cond_we}, {31'h0, ew});
    chk("R9", {31'h0, res_vld}, 32'h1);
    if (ew) chk("R7", {28'h0, cond}, {28'h0, ecnd});
  endtask

  initial begin
    rst_n = 1'b0; issue_vld = 1'b0; op_sel = 3'd0; record = 1'b0;
    opnd_a = '0; opnd_b = '0; imm = '0; carry_in = 1'b0; so_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", result, 32'h0);
    chk("R11", {27'h0, carry_out, cond}, 32'h0);
    chk("R11", {30'h0, cond_we, res_vld}, 32'h0);
    rst_n = 1'b1;
    for (int op = 0; op < 8; op++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
          for (int m = 0; m < 4; m++)
            run_one(op, corner(ia), corner(ib), m[0], m[1], m[0] ^ ia[0]);
    // idle hold after a known add: 0xFFFFFFFF + 1 -> 0 carry 1
    run_one(1, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    issue_vld = 1'b0; opnd_a = 32'h1234_5678; carry_in = 1'b0; op_sel = 3'd4;
    @(negedge clk);
    chk("R9", {30'h0, res_vld, cond_we}, 32'h0);
    chk("R9", result, 32'h0);
    chk("R9", {31'h0, carry_out}, 32'h1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule